// File: doc/BRIEF.md
# Command-Decoding Converter Read Slave

This block is the two-wire serial slave that sits in front of a three-channel 10-bit converter. The first byte after a START is both the device address and the command. Its upper nibble must equal the device identifier. The lower nibble selects between three actions: a conversion read, limit-register access, and monitor entry. It also picks a channel, or a rotation through all channels.

For a conversion read, the slave requests a sample from the converter as the command acknowledge ends. It then returns the result in two bytes. The upper byte starts with four zero bits, then echoes the channel, then carries the two top result bits. The lower byte carries the remaining eight bits. If the host acknowledges the lower byte and keeps clocking, another conversion is made and framed the same way. The channel either stays the same or moves to the next one. A host NACK or a STOP ends the read.

Limit-register and monitor commands are only decoded here. They are passed on through one-cycle strobes, together with the channel field, to neighbouring blocks. Both bus lines are resynchronised and glitch-filtered inside the block, which runs on the system clock.

Top module: `adc_cmd_slave`

## Requirements
- R1: The slave acknowledges a command byte only when bits 7..4 equal 4'b1001. When the STRAPPED parameter is set, these bits must instead equal {addr_sel, 1'b1}. For any other value it never drives SDA until the next START.
- R2: Bits 3 (E/C) and 0 (R/M) are decoded as follows. E/C=1 gives a one-cycle lim_stb with lim_rd equal to R/M. E/C=0 with R/M=0 gives a one-cycle mon_stb. E/C=0 with R/M=1 starts a conversion read. In every case cmd_ch shows bits 2..1, and at most one of the three strobes is high in a cycle.
- R3: In a conversion read, channel code 2'b00, 2'b01 or 2'b10 selects channel 0, 1 or 2. Code 2'b11 selects rotation, which starts on channel 0.
- R4: conv_req is a one-cycle pulse, raised after the rising SCL edge that ends the command acknowledge. conv_chan holds the channel to convert in the same cycle.
- R5: Each result goes out MSB first. The first byte is {4'b0000, channel[1:0], D9, D8}. The second byte is D7..D0.
- R6: A host ACK after the second byte raises a new conv_req on the same channel, and a new two-byte frame follows.
- R7: In rotation, each new conversion takes the next channel in the order 0, 1, 2, 0. The order wraps after channel NCHAN-1.
- R8: After a host NACK, the slave leaves SDA released until the next START. A STOP at any point returns the slave to idle with SDA released.
- R9: While chip_en_n is high, a command byte receives no acknowledge and produces no strobe or request.
- R10: sda_oe changes only while SCL is low. Transmitted bits are updated after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_n | input | 1 | Active-low enable for bus responses |
| addr_sel | input | 3 | Strap pins forming the identifier when STRAPPED is set |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_o | output | 1 | Data value driven when enabled (always low, open drain) |
| sda_oe | output | 1 | High to pull SDA low |
| conv_req | output | 1 | One-cycle request for a new conversion |
| conv_chan | output | 2 | Channel for the requested conversion |
| conv_done | input | 1 | Converter result valid strobe |
| conv_data | input | 10 | Converter result |
| cmd_ch | output | 2 | Channel field of the last accepted command |
| lim_stb | output | 1 | Limit-register command accepted |
| lim_rd | output | 1 | Limit command is a read (R/M bit) |
| mon_stb | output | 1 | Monitor entry command accepted |

## Verification
Two things happen on the same rising SCL edge. The host's ACK after a lower byte is sampled there, and the next conversion is requested there. In rotation, the channel also advances on that edge, so conv_chan must carry the new channel in the very cycle conv_req rises. The bench provokes this with long repeated and rotating reads. Each expected channel is placed in a queue before the ACK bit is driven, and a monitor compares conv_chan with the queued value on each request. The echoed channel bits in the following frame are then checked against the same expectation.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int CH_W   = 2;
  localparam int DATA_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_CACK, ST_TX, ST_RACK, ST_SKIP
  } slv_state_e;

  // identifier expected in the upper command nibble
  function automatic logic [3:0] dev_id(input logic strapped, input logic [2:0] pins);
    return strapped ? {pins, 1'b1} : 4'b1001;
  endfunction

  // rotation order: count up, wrap after the last channel
  function automatic logic [CH_W-1:0] chan_after(input logic [CH_W-1:0] ch,
                                                 input logic [CH_W-1:0] last);
    return (ch >= last) ? '0 : CH_W'(ch + 1'b1);
  endfunction

  // bit idx (0 = first on the wire) of upper (sel=0) or lower (sel=1) frame byte
  function automatic logic frame_bit(input logic sel, input logic [2:0] idx,
                                     input logic [CH_W-1:0] ch,
                                     input logic [DATA_W-1:0] d);
    logic [7:0] b;
    b = sel ? d[7:0] : {4'b0000, ch, d[9:8]};
    return b[3'd7 - idx];
  endfunction
endpackage

// File: rtl/adc_line_filter.sv
module adc_line_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [1:0]      sync_q;
  logic [FILT-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      hist_q <= {hist_q[FILT-2:0], sync_q[1]};
      if (&hist_q)       dout <= 1'b1;
      else if (~|hist_q) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_bus_events.sv
module adc_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/adc_cmd_slave.sv
module adc_cmd_slave
  import adc_cmd_pkg::*;
#(
  parameter int NCHAN    = 3,
  parameter bit STRAPPED = 1'b0,
  parameter int FILT     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en_n,
  input  logic [2:0]        addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic [CH_W-1:0]   cmd_ch,
  output logic              lim_stb,
  output logic              lim_rd,
  output logic              mon_stb
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCHAN - 1);

  logic [1:0] raw_lines, clean_lines;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    adc_line_filter #(.FILT(FILT)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (clean_lines[g])
    );
  end

  assign scl_f = clean_lines[1];
  assign sda_f = clean_lines[0];

  adc_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  slv_state_e          state_q;
  logic [2:0]          bitcnt_q;
  logic [7:0]          shreg_q;
  logic                byte_done_q;
  logic                ec_q, rm_q, auto_q;
  logic                byte_sel_q, ack_ok_q;
  logic [CH_W-1:0]     cur_ch_q;
  logic [DATA_W-1:0]   result_q;

  // named events for the checker
  logic id_match, ack_go, conv_cmd;
  assign id_match = (shreg_q[7:4] == dev_id(STRAPPED, addr_sel));
  assign ack_go   = (state_q == ST_CMD) && scl_fall && byte_done_q && id_match && !chip_en_n;
  assign conv_cmd = !ec_q && rm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else if (conv_done) result_q <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bitcnt_q    <= '0;
      shreg_q     <= '0;
      byte_done_q <= 1'b0;
      ec_q        <= 1'b0;
      rm_q        <= 1'b0;
      auto_q      <= 1'b0;
      byte_sel_q  <= 1'b0;
      ack_ok_q    <= 1'b0;
      cur_ch_q    <= '0;
      cmd_ch      <= '0;
      sda_oe      <= 1'b0;
      conv_req    <= 1'b0;
      lim_stb     <= 1'b0;
      lim_rd      <= 1'b0;
      mon_stb     <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      lim_stb  <= 1'b0;
      mon_stb  <= 1'b0;
      if (start_ev) begin
        state_q     <= ST_CMD;
        bitcnt_q    <= '0;
        byte_done_q <= 1'b0;
        sda_oe      <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_CMD: begin
            if (scl_rise) begin
              shreg_q  <= {shreg_q[6:0], sda_f};
              bitcnt_q <= 3'(bitcnt_q + 3'd1);
              if (bitcnt_q == 3'd7) byte_done_q <= 1'b1;
            end else if (scl_fall && byte_done_q) begin
              if (ack_go) begin
                sda_oe  <= 1'b1;
                state_q <= ST_CACK;
                ec_q    <= shreg_q[3];
                rm_q    <= shreg_q[0];
                auto_q  <= !shreg_q[3] && (shreg_q[2:1] == 2'b11);
                cmd_ch  <= shreg_q[2:1];
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_CACK: begin
            if (scl_rise) begin
              if (conv_cmd) begin
                conv_req <= 1'b1;
                cur_ch_q <= auto_q ? '0 : cmd_ch;
              end else if (ec_q) begin
                lim_stb <= 1'b1;
                lim_rd  <= rm_q;
              end else begin
                mon_stb <= 1'b1;
              end
            end else if (scl_fall) begin
              byte_sel_q <= 1'b0;
              bitcnt_q   <= '0;
              if (conv_cmd) begin
                state_q <= ST_TX;
                sda_oe  <= ~frame_bit(1'b0, 3'd0, cur_ch_q, result_q);
              end else begin
                state_q <= ST_SKIP;
                sda_oe  <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt_q == 3'd7) begin
                sda_oe   <= 1'b0;
                ack_ok_q <= 1'b0;
                state_q  <= ST_RACK;
              end else begin
                bitcnt_q <= 3'(bitcnt_q + 3'd1);
                sda_oe   <= ~frame_bit(byte_sel_q, 3'(bitcnt_q + 3'd1), cur_ch_q, result_q);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_f) begin
                state_q <= ST_SKIP;
              end else begin
                ack_ok_q <= 1'b1;
                if (byte_sel_q) begin
                  conv_req <= 1'b1;
                  cur_ch_q <= auto_q ? chan_after(cur_ch_q, LAST_CH) : cur_ch_q;
                end
              end
            end else if (scl_fall && ack_ok_q) begin
              state_q    <= ST_TX;
              bitcnt_q   <= '0;
              byte_sel_q <= ~byte_sel_q;
              sda_oe     <= ~frame_bit(~byte_sel_q, 3'd0, cur_ch_q, result_q);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_o     = 1'b0;
  assign conv_chan = cur_ch_q;
endmodule

// File: rtl/adc_cmd_slave_chk.sv
module adc_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       stop_ev,
  input logic       sda_oe,
  input logic       conv_req,
  input logic [1:0] conv_chan,
  input logic       lim_stb,
  input logic       mon_stb
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req); // R4

  AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_chan != 2'b11)); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_req, lim_stb, mon_stb})); // R2

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R8

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R10
endmodule

bind adc_cmd_slave adc_cmd_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .stop_ev  (stop_ev),
  .sda_oe   (sda_oe),
  .conv_req (conv_req),
  .conv_chan(conv_chan),
  .lim_stb  (lim_stb),
  .mon_stb  (mon_stb)
);

// File: tb/test_adc_cmd_slave.sv
`timescale 1ns/1ps
module test_adc_cmd_slave;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_line;
  logic       sda_o, sda_oe, conv_req, conv_done, lim_stb, lim_rd, mon_stb;
  logic [1:0] conv_chan, cmd_ch;
  logic [9:0] conv_data;

  int n_checks = 0, n_fail = 0;
  int n_req = 0, n_lim = 0, n_mon = 0, bad_edge = 0;
  int exp_n = 0;
  int exp_ch_q[$];
  int done_cnt = 0;
  logic [9:0] pend_val;
  logic prev_oe = 1'b0;
  bit reported = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  assign sda_line = m_sda & ~sda_oe;

  adc_cmd_slave i_adc_cmd_slave (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .addr_sel(3'b000),
    .scl_i(m_scl), .sda_i(sda_line), .sda_o(sda_o), .sda_oe(sda_oe),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .cmd_ch(cmd_ch), .lim_stb(lim_stb),
    .lim_rd(lim_rd), .mon_stb(mon_stb)
  );

  function automatic logic [9:0] model(input int ch, input int n);
    return 10'((ch * 331 + n * 53 + 100) % 1024);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected channel on each request, models the converter
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (rst_n && conv_req) begin
      if (exp_ch_q.size() == 0) begin
        check(1'b0, "R4 unexpected request", int'(conv_chan), -1);
      end else begin
        int e;
        e = exp_ch_q.pop_front();
        check(int'(conv_chan) == e, "R4/R7 request channel", int'(conv_chan), e);
      end
      pend_val = model(int'(conv_chan), n_req);
      n_req++;
      done_cnt = 6;
    end else if (done_cnt > 0) begin
      done_cnt--;
      if (done_cnt == 0) begin
        conv_done <= 1'b1;
        conv_data <= pend_val;
      end
    end
    if (rst_n && lim_stb) n_lim++;
    if (rst_n && mon_stb) n_mon++;
    if (rst_n && (sda_oe != prev_oe) && m_scl) bad_edge++;
    prev_oe = sda_oe;
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic xfer_bit(input logic bout, output logic bin);
    wq(); m_sda = bout; wq(); m_scl = 1'b1; wq(); bin = sda_line; wq(); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic r;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], r);
    xfer_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    logic r;
    for (int i = 0; i < 8; i++) begin
      xfer_bit(1'b1, r);
      b = {b[6:0], r};
    end
  endtask

  // driver: conversion read of n frames, pushes expected channels
  task automatic read_conv(input logic [7:0] cmd, input int n, input int ch0,
                           input bit rot, input string tag);
    bit acked;
    logic r;
    logic [7:0] hi, lo;
    logic [9:0] v;
    int ch, base;
    ch = ch0;
    base = n_req;
    exp_ch_q.push_back(ch);
    bus_start();
    send_byte(cmd, acked);
    check(acked, "R1 command acknowledged", int'(acked), 1);
    for (int k = 0; k < n; k++) begin
      v = model(ch, exp_n);
      exp_n++;
      recv_byte(hi);
      check(hi == {4'b0000, 2'(ch), v[9:8]}, {tag, " upper byte R5"}, int'(hi),
            int'({4'b0000, 2'(ch), v[9:8]}));
      xfer_bit(1'b0, r);
      recv_byte(lo);
      check(lo == v[7:0], {tag, " lower byte R5"}, int'(lo), int'(v[7:0]));
      if (k < n - 1) begin
        if (rot) ch = (ch == 2) ? 0 : ch + 1;
        exp_ch_q.push_back(ch);
        xfer_bit(1'b0, r);
      end else begin
        xfer_bit(1'b1, r);
      end
    end
    bus_stop();
    check(n_req - base == n, {tag, " request count R6"}, n_req - base, n);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    bit acked;
    logic [7:0] b;
    int lim0, mon0, req0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!sda_oe && !conv_req && !lim_stb && !mon_stb, "R8 reset quiet", int'(sda_oe), 0);

    read_conv(8'h93, 1, 1, 1'b0, "R3 single ch1");
    read_conv(8'h91, 1, 0, 1'b0, "R3 single ch0");
    read_conv(8'h95, 3, 2, 1'b0, "R6 repeat ch2");
    read_conv(8'h97, 4, 0, 1'b1, "R7 rotation");

    // R1: wrong identifier
    req0 = n_req;
    bus_start(); send_byte(8'hA3, acked); bus_stop();
    check(!acked, "R1 foreign id not acked", int'(acked), 0);
    check(n_req == req0, "R1 foreign id no request", n_req, req0);

    // R9: chip enable high
    chip_en_n = 1'b1; lim0 = n_lim;
    bus_start(); send_byte(8'h93, acked); bus_stop();
    check(!acked, "R9 disabled not acked", int'(acked), 0);
    bus_start(); send_byte(8'h9A, acked); bus_stop();
    check(n_req == req0 && n_lim == lim0, "R9 disabled no strobes", n_lim, lim0);
    chip_en_n = 1'b0;

    // R2: limit write, limit read, monitor entry
    lim0 = n_lim; mon0 = n_mon;
    bus_start(); send_byte(8'h9A, acked); bus_stop();
    check(acked && n_lim == lim0 + 1, "R2 limit write strobe", n_lim, lim0 + 1);
    check(lim_rd == 1'b0 && cmd_ch == 2'b01, "R2 limit write fields", int'({lim_rd, cmd_ch}), 1);
    bus_start(); send_byte(8'h9D, acked); bus_stop();
    check(lim_rd == 1'b1 && cmd_ch == 2'b10, "R2 limit read fields", int'({lim_rd, cmd_ch}), 6);
    bus_start(); send_byte(8'h96, acked); bus_stop();
    check(acked && n_mon == mon0 + 1, "R2 monitor strobe", n_mon, mon0 + 1);
    check(n_req == req0, "R2 no conversion on side commands", n_req, req0);

    // R8: NACK releases the line
    exp_ch_q.push_back(1);
    exp_n++;
    bus_start(); send_byte(8'h93, acked);
    recv_byte(b);
    begin logic r; xfer_bit(1'b1, r); end
    recv_byte(b);
    check(b == 8'hFF, "R8 released after NACK", int'(b), 8'hFF);
    bus_stop();

    // R8: STOP in mid read, then a fresh read works
    exp_ch_q.push_back(2);
    exp_n++;
    bus_start(); send_byte(8'h95, acked); recv_byte(b); bus_stop();
    check(!sda_oe, "R8 idle after STOP", int'(sda_oe), 0);
    read_conv(8'h93, 1, 1, 1'b0, "R8 after STOP");

    check(exp_ch_q.size() == 0, "R4 all expected requests seen", exp_ch_q.size(), 0);
    check(bad_edge == 0, "R10 sda_oe moves only with SCL low", bad_edge, 0);
    report();
  end
endmodule